// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is a chain of edge-triggered storage stages, eight by default, that takes serial data in at one end and shows every stage on a parallel bus. The bit that enters the first stage is the AND of two serial pins. Either pin can therefore act as an active-high enable for the other. A design that needs only one data line ties the spare pin high or ties it to the data pin, and the block then works as an ordinary single-input shifter.

On each rising clock edge, every stage passes its bit to the next higher-numbered stage. Stage 0 takes the gated input, and the bit that was in the top stage is lost. An active-low clear empties every stage at once, with no clock needed. While the clear is held low it overrides the clock and both data pins. Shifting starts again on the first rising edge after the clear is released.

The block has no state machine. Its only state is the contents of the chain, and it uses only two conditions: clear held and running.

Top module: `gated_sipo_shifter`

## Requirements
- R1: On each rising edge of `clk` with `clr_n` high, `taps[i]` takes the value that `taps[i-1]` held just before the edge, for every i from 1 to STAGES-1.
- R2: On each rising edge of `clk` with `clr_n` high, `taps[0]` takes `din_a & din_b` as sampled at that edge.
- R3: When either serial pin is low at a rising edge, a 0 enters `taps[0]`, whatever the other pin holds.
- R4: With `din_b` tied high, or with `din_b` tied to `din_a`, the block shifts `din_a` alone into the chain as a plain single-input shift register.
- R5: When `clr_n` falls, all of `taps` reads 0 at once, even between clock edges.
- R6: While `clr_n` is held low, `taps` stays all-zero regardless of clock edges and data pins.
- R7: On the first rising edge after `clr_n` returns high, `taps[0]` loads `din_a & din_b` and every higher stage reads 0.
- R8: `taps` changes only on a rising edge of `clk` or when `clr_n` falls. A change on the data pins between edges has no effect on the outputs.
- R9: The bit held in `taps[STAGES-1]` is discarded at each shift. After STAGES shifts of 0, the bus is all-zero no matter what it held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| din_a | input | 1 | Serial data pin A, ANDed with B |
| din_b | input | 1 | Serial data pin B, ANDed with A |
| taps | output | STAGES | Parallel view of the stages, bit 0 is the entry stage |

## Verification
Every stage is a port bit, so a wrong stored value is visible at once: it shows on `taps` in the same cycle it is stored. A stage that was not cleared, a gate that passes the wrong pin, or a shift that skips a position shows as a mismatch on the next edge. The error then keeps moving up the bus for up to STAGES-1 more cycles, so a late check still catches it. The reference queue is compared on every falling clock edge. It is also compared directly after a clear that arrives mid-cycle, so a clear that waits for the clock is caught before the next edge.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    // Default chain length.
    localparam int unsigned SIPO_STAGES_DEF = 8;

    // Combines the two serial pins into the bit that enters stage 0.
    function automatic logic sipo_gate(input logic a, input logic b);
        return a & b;
    endfunction
endpackage

// File: rtl/sipo_entry_gate.sv
module sipo_entry_gate (
    input  logic din_a,
    input  logic din_b,
    output logic bit_in
);
    // Each pin enables the other.
    always_comb bit_in = sipo_pkg::sipo_gate(din_a, din_b);
endmodule

// File: rtl/sipo_cell.sv
module sipo_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    // One stage: the asynchronous clear wins over the clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/gated_sipo_shifter.sv
module gated_sipo_shifter #(
    parameter int unsigned STAGES = sipo_pkg::SIPO_STAGES_DEF
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              din_a,
    input  logic              din_b,
    output logic [STAGES-1:0] taps
);
    localparam int unsigned LINKS = STAGES + 1;

    // link[0] is the gated entry bit; link[i+1] is the output of stage i.
    logic [LINKS-1:0] link;

    sipo_entry_gate u_gate (
        .din_a  (din_a),
        .din_b  (din_b),
        .bit_in (link[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        sipo_cell u_cell (
            .clk   (clk),
            .clr_n (clr_n),
            .d     (link[i]),
            .q     (link[i+1])
        );
    end

    assign taps = link[LINKS-1:1];
endmodule

// File: rtl/sipo_checker.sv
module sipo_checker #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              din_a,
    input logic              din_b,
    input logic [STAGES-1:0] taps
);
    // Set once an edge has passed with clr_n high since the last clear.
    logic fresh;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) fresh <= 1'b0;
        else        fresh <= 1'b1;
    end

    p_entry_r2: assert property (@(posedge clk) disable iff (!clr_n)
        fresh |-> taps[0] == ($past(din_a) & $past(din_b)));

    p_gate_a_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (fresh && !$past(din_a)) |-> !taps[0]);

    p_gate_b_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (fresh && !$past(din_b)) |-> !taps[0]);

    p_hold_clear_r6: assert property (@(posedge clk)
        !clr_n |-> taps == '0);

    p_clear_r5: assert property (@(negedge clk)
        !clr_n |-> taps == '0);

    if (STAGES > 1) begin : g_multi
        p_shift_r1: assert property (@(posedge clk) disable iff (!clr_n)
            fresh |-> taps[STAGES-1:1] == $past(taps[STAGES-2:0]));

        p_release_r7: assert property (@(posedge clk) disable iff (!clr_n)
            !fresh |=> (taps[STAGES-1:1] == '0) &&
                       (taps[0] == ($past(din_a) & $past(din_b))));
    end
endmodule

bind gated_sipo_shifter sipo_checker #(.STAGES(STAGES)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .din_a (din_a),
    .din_b (din_b),
    .taps  (taps)
);

// File: tb/gated_sipo_shifter_test.sv
module gated_sipo_shifter_test;
    localparam int unsigned STAGES = 8;

    logic              clk = 1'b0;
    logic              clr_n = 1'b0;
    logic              din_a = 1'b0;
    logic              din_b = 1'b0;
    logic [STAGES-1:0] taps;

    int compared = 0;
    int mismatched = 0;
    bit model[$];

    gated_sipo_shifter #(.STAGES(STAGES)) uut (
        .clk(clk), .clr_n(clr_n), .din_a(din_a), .din_b(din_b), .taps(taps)
    );

    always #5 clk = ~clk;

    // Reference: index 0 is the entry stage; clear empties it to zeros.
    initial for (int i = 0; i < STAGES; i++) model.push_back(1'b0);

    always @(negedge clr_n) begin
        for (int i = 0; i < STAGES; i++) model[i] = 1'b0;
    end

    always @(posedge clk) begin
        if (clr_n) begin
            model.push_front(din_a & din_b);
            void'(model.pop_back());
        end
    end

    function automatic logic [STAGES-1:0] expected();
        logic [STAGES-1:0] v;
        for (int i = 0; i < STAGES; i++) v[i] = model[i];
        return v;
    endfunction

    task automatic check(input string tag);
        logic [STAGES-1:0] e;
        e = expected();
        compared++;
        if (taps !== e) begin
            mismatched++;
            $display("FAIL %s: taps=%b expected=%b at %0t", tag, taps, e, $time);
        end
    endtask

    // Compare at the falling edge, then drive the next inputs.
    task automatic step(input logic a, input logic b, input string tag);
        @(negedge clk);
        check(tag);
        din_a = a;
        din_b = b;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        // R6: clear held while clock and data toggle.
        for (int i = 0; i < 6; i++) step(i[0], ~i[0], "R6 clear held");
        step(1'b1, 1'b1, "R6 reset state");

        // R7: release mid-cycle; the first edge loads the AND, zeros behind it.
        #2 clr_n = 1'b1;
        step(1'b0, 1'b0, "R7 first shift after release");
        step(1'b1, 1'b1, "R7 second shift");

        // R1/R2: random patterns on both pins.
        for (int i = 0; i < 40; i++)
            step(1'($urandom), 1'($urandom), "R1 R2 random shift");

        // R3: one pin low forces zeros in.
        for (int i = 0; i < 10; i++) step(1'b0, 1'($urandom), "R3 din_a low");
        for (int i = 0; i < 10; i++) step(1'($urandom), 1'b0, "R3 din_b low");

        // R4: spare pin tied high, then tied to the data pin.
        for (int i = 0; i < 20; i++) step(1'($urandom), 1'b1, "R4 tied high");
        for (int i = 0; i < 20; i++) begin
            logic v;
            v = 1'($urandom);
            step(v, v, "R4 tied together");
        end

        // R9: fill with ones, then shift zeros until all old bits fall out.
        for (int i = 0; i < STAGES; i++) step(1'b1, 1'b1, "R9 fill ones");
        for (int i = 0; i < STAGES; i++) step(1'b0, 1'b1, "R9 drain");
        @(negedge clk);
        compared++;
        if (taps !== '0) begin
            mismatched++;
            $display("FAIL R9: taps=%b expected=%b", taps, {STAGES{1'b0}});
        end

        // R8: data toggles between edges must not reach the outputs.
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R8 setup");
        @(posedge clk);
        #2 din_a = 1'b0;
        #1 din_b = 1'b0;
        #1 check("R8 no change between edges");
        din_a = 1'b1;
        din_b = 1'b1;

        // R5: clear asserted between edges takes effect at once.
        @(posedge clk);
        #2 clr_n = 1'b0;
        #1 check("R5 immediate clear");
        step(1'b1, 1'b1, "R6 clear over data");
        step(1'b1, 1'b1, "R6 clear over data");
        #2 clr_n = 1'b1;
        step(1'b1, 1'b0, "R7 restart after mid-cycle clear");
        for (int i = 0; i < 12; i++)
            step(1'($urandom), 1'($urandom), "R1 R2 after restart");

        // Short clear pulse that falls and rises between two edges.
        @(posedge clk);
        #1 clr_n = 1'b0;
        #1 check("R5 short pulse");
        #1 clr_n = 1'b1;
        for (int i = 0; i < 10; i++)
            step(1'($urandom), 1'($urandom), "R7 after short pulse");

        step(1'b0, 1'b0, "R1 final");
        finish_up();
    end
endmodule